// File: doc/BRIEF.md
# Four-Channel DMA/CPU Bus Ownership Arbiter

This block decides, cycle by cycle, whether the CPU or one of four DMA channels owns the system bus. Requests from the channels are gathered over a sampling period that runs from one bus-clock falling edge to the next. The surrounding logic marks the end of each period with a one-cycle strobe. At that strobe, every enabled channel that asked for the bus during the period gets its pending flag set. Repeated asks on a channel collapse into a single flag.

Ownership strictly alternates. The CPU owns the bus after reset. When the CPU reports a finished access and at least one enabled channel is pending, the lowest-numbered such channel is granted the bus for exactly one transfer, and its pending flag is cleared at that moment. When that transfer reports done, the bus goes back to the CPU. The CPU must then finish one more access before any channel can win again. If nothing is pending, the CPU keeps the bus.

Top module: `dma_bus_arbiter`

## Requirements
- R1: While rst_n is low and in the first cycle after its release, cpu_gnt is 1, dma_gnt is 0 and pend is 0.
- R2: A request seen in any cycle of a sampling period, including the strobe cycle itself, sets that channel's pend bit on the clock edge where sample_stb is high. It is visible in the following cycle. Without a strobe, no pend bit becomes set.
- R3: All channels that requested within one sampling period have their pend bits set on the same edge.
- R4: A request is recorded only if the channel's chan_en bit is 1 at the strobe edge. A pending channel whose chan_en bit is 0 is never granted; its pend bit remains set.
- R5: In a cycle where the CPU owns the bus, cpu_done is 1 and (pend & chan_en) is nonzero, the next cycle shows cpu_gnt 0 and dma_gnt one-hot at the lowest-indexed bit of (pend & chan_en). Bit 0 has the highest priority.
- R6: On the grant edge, the winner's pend bit clears. This clear takes precedence over a strobe on the same edge. Any number of requests before the grant yield exactly one transfer.
- R7: A granted channel keeps dma_gnt until a cycle with xfer_done 1; the next cycle returns cpu_gnt to 1. cpu_done has no effect while a channel owns the bus.
- R8: After the bus returns to the CPU, another grant needs a new cycle with cpu_done 1. While nothing eligible is pending, the CPU keeps the bus indefinitely. xfer_done has no effect while the CPU owns the bus.
- R9: A request on a channel that is sampled during its own transfer sets its pend bit again, and that channel is served on a later turn.
- R10: In every cycle exactly one owner exists: cpu_gnt is 1 with dma_gnt 0, or cpu_gnt is 0 with dma_gnt one-hot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Arbiter clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, already synchronized on release |
| sample_stb | input | 1 | One-cycle strobe closing a sampling period (bus-clock falling edge) |
| chan_en | input | 4 | Per-channel enable |
| dma_req | input | 4 | Per-channel transfer request |
| cpu_done | input | 1 | CPU finished one bus access this cycle |
| xfer_done | input | 1 | Granted DMA channel finished its transfer this cycle |
| pend | output | 4 | Per-channel pending flags |
| dma_gnt | output | 4 | One-hot DMA bus grant |
| cpu_gnt | output | 1 | CPU owns the bus |

## Verification
Two behaviours can land on the same edge: a sampling strobe and a grant that clears the winning channel's pending flag. The bench provokes this by raising sample_stb together with cpu_done while the about-to-win channel is still requesting. It then checks that the flag ends up clear rather than set again. A second overlap occurs when a strobe lands during a channel's own transfer. Here the bench expects the flag to come back, and it expects a second transfer after the CPU has made another access. A behavioural reference model, compared on every cycle, also judges a long random stretch in which strobes, enables, both done pulses and requests all collide freely.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic {
    CPU_OWN = 1'b0,
    DMA_OWN = 1'b1
  } owner_e;
endpackage

// File: rtl/dma_req_sampler.sv
module dma_req_sampler #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sample_stb,
  input  logic [NCH-1:0] chan_en,
  input  logic [NCH-1:0] req,
  input  logic [NCH-1:0] clr,
  output logic [NCH-1:0] pend
);
  logic [NCH-1:0] win_q, win_d;
  logic [NCH-1:0] pend_q, pend_d;
  logic [NCH-1:0] commit;

  always_comb begin
    commit = sample_stb ? ((win_q | req) & chan_en) : '0;
    pend_d = (pend_q | commit) & ~clr;
    win_d  = sample_stb ? '0 : (win_q | req);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      pend_q <= '0;
    end else begin
      win_q  <= win_d;
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;

  // R2
  no_set_without_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb |=> ((pend_q & ~$past(pend_q)) == '0));

  // R4
  no_set_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && !chan_en[0] && !pend_q[0]) |=> !pend_q[0]);
endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
  parameter int NCH = 4
) (
  input  logic [NCH-1:0] vec,
  output logic [NCH-1:0] pick,
  output logic           any
);
  logic [NCH-1:0] seen;

  for (genvar g = 0; g < NCH; g++) begin : g_pick
    if (g == 0) begin : g_first
      assign pick[g] = vec[g];
      assign seen[g] = vec[g];
    end else begin : g_rest
      assign pick[g] = vec[g] & ~seen[g-1];
      assign seen[g] = seen[g-1] | vec[g];
    end
  end

  assign any = seen[NCH-1];

  // R5
  pick_onehot_chk: assert final ($onehot0(pick));
endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sample_stb,
  input  logic [NCH-1:0] chan_en,
  input  logic [NCH-1:0] dma_req,
  input  logic           cpu_done,
  input  logic           xfer_done,
  output logic [NCH-1:0] pend,
  output logic [NCH-1:0] dma_gnt,
  output logic           cpu_gnt
);
  localparam logic [NCH-1:0] ONE = NCH'(1);

  owner_e         own_q, own_d;
  logic [NCH-1:0] gnt_q, gnt_d;
  logic [NCH-1:0] elig, pick, clr;
  logic           any_elig, take;

  dma_req_sampler #(.NCH(NCH)) u_sampler (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_stb (sample_stb),
    .chan_en    (chan_en),
    .req        (dma_req),
    .clr        (clr),
    .pend       (pend)
  );

  assign elig = pend & chan_en;

  dma_prio_pick #(.NCH(NCH)) u_pick (
    .vec  (elig),
    .pick (pick),
    .any  (any_elig)
  );

  always_comb begin
    own_d = own_q;
    gnt_d = gnt_q;
    take  = 1'b0;
    unique case (own_q)
      CPU_OWN: begin
        if (cpu_done && any_elig) begin
          take  = 1'b1;
          own_d = DMA_OWN;
          gnt_d = pick;
        end
      end
      DMA_OWN: begin
        if (xfer_done) begin
          own_d = CPU_OWN;
          gnt_d = '0;
        end
      end
      default: begin
        own_d = CPU_OWN;
        gnt_d = '0;
      end
    endcase
    clr = take ? pick : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q <= CPU_OWN;
      gnt_q <= '0;
    end else begin
      own_q <= own_d;
      gnt_q <= gnt_d;
    end
  end

  assign dma_gnt = gnt_q;
  assign cpu_gnt = (own_q == CPU_OWN);

  // R10
  single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_gnt && dma_gnt == '0) || (!cpu_gnt && $onehot(dma_gnt)));

  // R5
  grant_needs_cpu_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|dma_gnt) |-> $past(cpu_done));

  // R5
  grant_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|dma_gnt) |-> ((($past(pend) & $past(chan_en)) & (dma_gnt - ONE)) == '0));

  // R7
  hold_until_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|dma_gnt) && !xfer_done) |=> $stable(dma_gnt));

  // R6
  clear_on_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|dma_gnt) |-> ((pend & dma_gnt) == '0));
endmodule

// File: tb/tb_dma_bus_arbiter.sv
module tb_dma_bus_arbiter;
  localparam int  NCH      = 4;
  localparam time CLK_PER  = 10ns;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           sample_stb;
  logic [NCH-1:0] chan_en;
  logic [NCH-1:0] dma_req;
  logic           cpu_done;
  logic           xfer_done;
  logic [NCH-1:0] pend;
  logic [NCH-1:0] dma_gnt;
  logic           cpu_gnt;

  int    n_run  = 0;
  int    n_fail = 0;
  string tag    = "R1";
  bit    done   = 1'b0;

  // behavioural reference state
  bit m_pend [NCH];
  bit m_win  [NCH];
  bit m_dma;
  int m_gnt;

  always #(CLK_PER/2) clk = ~clk;

  dma_bus_arbiter #(.NCH(NCH)) dut (
    .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .chan_en(chan_en),
    .dma_req(dma_req), .cpu_done(cpu_done), .xfer_done(xfer_done),
    .pend(pend), .dma_gnt(dma_gnt), .cpu_gnt(cpu_gnt)
  );

  function automatic logic [NCH-1:0] exp_pend();
    logic [NCH-1:0] v;
    for (int i = 0; i < NCH; i++) v[i] = m_pend[i];
    return v;
  endfunction

  function automatic logic [NCH-1:0] exp_gnt();
    logic [NCH-1:0] v = '0;
    if (m_dma) v[m_gnt] = 1'b1;
    return v;
  endfunction

  task automatic compare();
    n_run++;
    if (pend !== exp_pend() || dma_gnt !== exp_gnt() || cpu_gnt !== !m_dma) begin
      n_fail++;
      $display("FAIL %s: pend=%b dma_gnt=%b cpu_gnt=%b expected pend=%b dma_gnt=%b cpu_gnt=%b",
               tag, pend, dma_gnt, cpu_gnt, exp_pend(), exp_gnt(), !m_dma);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NCH; i++) begin m_pend[i] = 0; m_win[i] = 0; end
    m_dma = 0;
    m_gnt = 0;
  endtask

  task automatic model_edge();
    int win_ch = -1;
    if (!m_dma) begin
      if (cpu_done) begin
        for (int i = NCH-1; i >= 0; i--)
          if (m_pend[i] && chan_en[i]) win_ch = i;
        if (win_ch >= 0) begin m_dma = 1; m_gnt = win_ch; end
      end
    end else if (xfer_done) begin
      m_dma = 0;
    end
    for (int i = 0; i < NCH; i++) begin
      if (sample_stb && chan_en[i] && (m_win[i] || dma_req[i])) m_pend[i] = 1;
      m_win[i] = sample_stb ? 1'b0 : (m_win[i] | dma_req[i]);
    end
    if (win_ch >= 0) m_pend[win_ch] = 0;
  endtask

  // one cycle: check outputs, drive new inputs, advance model for next edge
  task automatic step(input bit stb, input logic [NCH-1:0] en, input logic [NCH-1:0] rq,
                      input bit cd, input bit xd);
    @(negedge clk);
    compare();
    sample_stb = stb; chan_en = en; dma_req = rq; cpu_done = cd; xfer_done = xd;
    model_edge();
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PER * 150000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; sample_stb = 0; chan_en = '0; dma_req = '0; cpu_done = 0; xfer_done = 0;
    model_reset();
    repeat (3) @(negedge clk);
    tag = "R1"; compare();
    rst_n = 1'b1;
    step(0, 4'hF, 4'h0, 0, 0);
    step(0, 4'hF, 4'h0, 1, 1);

    // R2: mid-period request recorded only at strobe
    tag = "R2";
    step(0, 4'hF, 4'b0100, 0, 0);
    step(0, 4'hF, 4'b0000, 0, 0);
    step(0, 4'hF, 4'b0000, 0, 0);
    step(1, 4'hF, 4'b0000, 0, 0);
    step(0, 4'hF, 4'b0000, 0, 0);

    // R3: several channels in one period set together
    tag = "R3";
    step(0, 4'hF, 4'b0001, 0, 0);
    step(0, 4'hF, 4'b1000, 0, 0);
    step(1, 4'hF, 4'b0010, 0, 0);
    step(0, 4'hF, 4'b0000, 0, 0);

    // R5/R7: grant ch0, cpu_done ignored during transfer
    tag = "R5";
    step(0, 4'hF, 4'h0, 1, 0);
    tag = "R7";
    step(0, 4'hF, 4'h0, 1, 0);
    step(0, 4'hF, 4'h0, 1, 0);
    step(0, 4'hF, 4'h0, 0, 1);
    // R8: xfer_done ignored for CPU, needs new cpu_done
    tag = "R8";
    step(0, 4'hF, 4'h0, 0, 1);
    step(0, 4'hF, 4'h0, 0, 0);
    step(0, 4'hF, 4'h0, 1, 0);
    step(0, 4'hF, 4'h0, 0, 1);
    step(0, 4'hF, 4'h0, 1, 0);
    step(0, 4'hF, 4'h0, 0, 1);
    step(0, 4'hF, 4'h0, 1, 0);
    step(0, 4'hF, 4'h0, 0, 1);
    repeat (4) step(0, 4'hF, 4'h0, 1, 0);

    // R6: repeated requests collapse; clear beats coincident strobe
    tag = "R6";
    step(1, 4'hF, 4'b0010, 0, 0);
    step(1, 4'hF, 4'b0010, 0, 0);
    step(1, 4'hF, 4'b0010, 1, 0);
    step(0, 4'hF, 4'b0000, 0, 1);
    step(0, 4'hF, 4'b0000, 1, 0);
    step(0, 4'hF, 4'b0000, 0, 0);

    // R9: request during own transfer re-pends
    tag = "R9";
    step(1, 4'hF, 4'b1000, 0, 0);
    step(0, 4'hF, 4'b0000, 1, 0);
    step(1, 4'hF, 4'b1000, 0, 0);
    step(0, 4'hF, 4'b0000, 0, 1);
    step(0, 4'hF, 4'b0000, 1, 0);
    step(0, 4'hF, 4'b0000, 0, 1);
    step(0, 4'hF, 4'b0000, 0, 0);

    // R4: disabled channel neither recorded nor granted
    tag = "R4";
    step(1, 4'b1011, 4'b0100, 0, 0);
    step(0, 4'b1111, 4'b0000, 0, 0);
    step(1, 4'b1111, 4'b0100, 0, 0);
    step(0, 4'b1011, 4'b0000, 1, 0);
    step(0, 4'b1011, 4'b0000, 1, 0);
    step(0, 4'b1111, 4'b0000, 1, 0);
    step(0, 4'b1111, 4'b0000, 0, 1);
    step(0, 4'b1111, 4'b0000, 0, 0);

    // R10: free-running random collisions
    tag = "R10";
    for (int k = 0; k < 3000; k++) begin
      logic [NCH-1:0] en_r = 4'hF;
      if (($urandom % 8) == 0) en_r = NCH'($urandom);
      step(($urandom % 3) == 0, en_r, NCH'($urandom), ($urandom % 2) == 0, ($urandom % 3) == 0);
    end
    step(0, 4'hF, 4'h0, 0, 0);
    @(negedge clk);
    compare();

    done = 1'b1;
    finish_run();
  end
endmodule